// File: doc/BRIEF.md
# One-Shot Countdown Event Timer

This block is a single-channel, 32-bit down-counting event timer sitting on a plain word-wide register bus. Software arms it by writing a tick count into the count register. The write itself starts the countdown, so no separate start command exists. When the count runs out, the counter halts and a sticky pending flag is set. The interrupt line is driven whenever that flag is set and interrupts are enabled.

A control register holds a tick-gate bit, an interrupt-enable bit and a write-only clear strobe. The tick gate already set before a write decides whether that write can do anything. A count write or a clear strobe that arrives while the gate is off is dropped. This forces the usual shutdown order: first open the gate, then write the clear strobe with the gate bit still set, then write zero. Dropping the gate freezes the count where it is, and reopening it resumes a countdown that still has ticks left.

Top module: `tmr_syst`

## Requirements
- R1: After reset the control register reads 0, the count register reads 0 and `irq_o` is low.
- R2: The control register sits at byte offset 0x40 and the count register at 0x44. Control bit 0 is the tick gate and bit 1 is the interrupt enable; both read back as written. Bit 4 is the clear strobe and reads back as 0, as do all other control bits.
- R3: A write to the count register, made while the tick gate is already set, loads the written value. From the next clock edge on, the count drops by one on each edge while the gate stays set.
- R4: When the count reaches 0, the counter stops at 0 and the pending flag is set. A value N is therefore pending after max(N,1) gated edges, which includes a loaded value of 0.
- R5: `irq_o` is high exactly when the pending flag and the interrupt enable are both set. Setting the enable after expiry raises `irq_o`.
- R6: A count-register write made while the tick gate is clear has no effect on the count and does not start a countdown.
- R7: Writing the control register with bit 4 set clears the pending flag, but only if the tick gate was already set before that write. A clear strobe written while the gate was clear is ignored, so clearing takes two writes starting from a closed gate.
- R8: Clearing the tick gate freezes the count. Setting the gate again resumes the countdown from the frozen value.
- R9: Reopening the gate after an expiry does not restart counting; the count stays at 0.
- R10: Writing 0 to the control register drops `irq_o` and stops all counting.
- R11: If an expiry and an accepted clear strobe happen on the same edge, the pending flag stays set. A reload does not clear a flag that is already pending.
- R12: The full value 0xFFFFFFFF can be loaded and counts down to 0xFFFFFFFE on the next gated edge.
- R13: A count-register write made during a countdown restarts the countdown from the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one write per asserted cycle |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Level interrupt |

## Verification
If the gate, the count or the pending flag holds a wrong value, it shows up at the ports within one cycle. The count register reads the live count every cycle, so a missed or extra decrement, or a load that should have been dropped, is visible at the next read. A pending flag that is set too early, set too late or wrongly cleared moves the edge of `irq_o` by at least one cycle whenever the interrupt is enabled. Because the gate and enable bits read back directly, a dropped or mis-decoded control write is also visible right away.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int unsigned CTRL_OFS = 32'h40;
    localparam int unsigned CNT_OFS  = 32'h44;
    localparam int unsigned BIT_GATE = 0;
    localparam int unsigned BIT_IEN  = 1;
    localparam int unsigned BIT_CLR  = 4;

    typedef struct packed {
        logic gate;
        logic ien;
    } ctrl_t;
endpackage

// File: rtl/tmr_bus_dec.sv
module tmr_bus_dec #(
    parameter int unsigned AW = 8
) (
    input  logic [AW-1:0] addr,
    input  logic          wr,
    output logic          ctrl_sel,
    output logic          cnt_sel,
    output logic          ctrl_wr,
    output logic          cnt_wr
);
    localparam logic [AW-1:0] CTRL_A = AW'(tmr_pkg::CTRL_OFS);
    localparam logic [AW-1:0] CNT_A  = AW'(tmr_pkg::CNT_OFS);

    always_comb begin
        ctrl_sel = (addr == CTRL_A);
        cnt_sel  = (addr == CNT_A);
        ctrl_wr  = wr && ctrl_sel;
        cnt_wr   = wr && cnt_sel;
    end
endmodule

// File: rtl/tmr_ctrl_reg.sv
module tmr_ctrl_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wd_gate,
    input  logic wd_ien,
    input  logic wd_clr,
    output logic gate,
    output logic ien,
    output logic clr_pulse
);
    tmr_pkg::ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d    = ctrl_q;
        clr_pulse = wr_en && wd_clr && ctrl_q.gate;
        if (wr_en) begin
            ctrl_d.gate = wd_gate;
            ctrl_d.ien  = wd_ien;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign gate = ctrl_q.gate;
    assign ien  = ctrl_q.ien;
endmodule

// File: rtl/tmr_down_cnt.sv
module tmr_down_cnt #(
    parameter int unsigned CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          clr,
    output logic [CW-1:0] cnt,
    output logic          pend,
    output logic          run
);
    localparam logic [CW-1:0] ONE = CW'(1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          run;
        logic          pend;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    expire;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (clr) st_d.pend = 1'b0;
        if (load) begin
            st_d.cnt = load_val;
            st_d.run = 1'b1;
        end else if (tick_en && st_q.run) begin
            if (st_q.cnt <= ONE) begin
                expire   = 1'b1;
                st_d.cnt = '0;
                st_d.run = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - ONE;
            end
        end
        if (expire) st_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt  = st_q.cnt;
    assign pend = st_q.pend;
    assign run  = st_q.run;
endmodule

// File: rtl/tmr_syst.sv
module tmr_syst #(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq_o
);
    logic          ctrl_sel, cnt_sel, ctrl_wr, cnt_wr;
    logic          gate, ien, clr_pulse, val_wr;
    logic [DW-1:0] cnt;
    logic          pend, run;

    tmr_bus_dec #(.AW(AW)) u_dec (
        .addr(bus_addr), .wr(bus_wr),
        .ctrl_sel(ctrl_sel), .cnt_sel(cnt_sel),
        .ctrl_wr(ctrl_wr), .cnt_wr(cnt_wr)
    );

    tmr_ctrl_reg u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(ctrl_wr),
        .wd_gate(bus_wdata[tmr_pkg::BIT_GATE]),
        .wd_ien(bus_wdata[tmr_pkg::BIT_IEN]),
        .wd_clr(bus_wdata[tmr_pkg::BIT_CLR]),
        .gate(gate), .ien(ien), .clr_pulse(clr_pulse)
    );

    assign val_wr = cnt_wr && gate;

    tmr_down_cnt #(.CW(DW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick_en(gate),
        .load(val_wr), .load_val(bus_wdata), .clr(clr_pulse),
        .cnt(cnt), .pend(pend), .run(run)
    );

    always_comb begin
        bus_rdata = '0;
        if (ctrl_sel) begin
            bus_rdata[tmr_pkg::BIT_GATE] = gate;
            bus_rdata[tmr_pkg::BIT_IEN]  = ien;
        end else if (cnt_sel) begin
            bus_rdata = cnt;
        end
    end

    assign irq_o = pend && ien;
endmodule

// File: rtl/tmr_syst_chk.sv
module tmr_syst_chk #(
    parameter int unsigned CW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          irq_o,
    input logic          gate,
    input logic          ien,
    input logic          clr,
    input logic          load,
    input logic [CW-1:0] cnt,
    input logic          pend,
    input logic          run
);
    localparam logic [CW-1:0] ONE = CW'(1);

    // R8, R6: closed gate leaves the count untouched
    a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !gate |=> $stable(cnt));
    // R3
    a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (gate && run && cnt > ONE && !load) |=> cnt == $past(cnt) - ONE);
    // R4
    a_r4_pend_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> (cnt == '0 && !run));
    // R4, R9
    a_r4_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !load && !run) |=> cnt == '0);
    // R7
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !(gate && run && cnt <= ONE && !load)) |=> !pend);
    // R5
    a_r5_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> (pend && ien));
endmodule

bind tmr_syst tmr_syst_chk #(.CW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .gate(gate), .ien(ien),
    .clr(clr_pulse), .load(val_wr), .cnt(cnt), .pend(pend), .run(run)
);

// File: tb/tb_tmr_syst.sv
module tb_tmr_syst;
    localparam logic [7:0] A_CTRL = 8'h40;
    localparam logic [7:0] A_CNT  = 8'h44;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = A_CTRL;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;
    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    tmr_syst dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called at a falling edge; write lands on the next rising edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clear_pend();
        wr(A_CTRL, 32'h13);
        chk("R7 clear", {31'b0, irq_o}, 32'd0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_CTRL, v); chk("R1 ctrl", v, 0);
        rd(A_CNT, v);  chk("R1 count", v, 0);
        chk("R1 irq", {31'b0, irq_o}, 0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(A_CTRL, 32'h13); rd(A_CTRL, v); chk("R2 bits", v, 32'h3);
        wr(A_CTRL, 32'hFFFF_FFFF); rd(A_CTRL, v); chk("R2 all ones", v, 32'h3);
        wr(A_CTRL, 32'h2); rd(A_CTRL, v); chk("R2 ien only", v, 32'h2);
        wr(A_CTRL, 32'h1); rd(A_CTRL, v); chk("R2 gate only", v, 32'h1);
    endtask

    task automatic t_countdown();
        logic [31:0] v;
        wr(A_CNT, 5); rd(A_CNT, v); chk("R3 load", v, 5);
        tick(2); rd(A_CNT, v); chk("R3 dec", v, 3);
        tick(2); rd(A_CNT, v); chk("R3 dec", v, 1);
        chk("R4 not yet", {31'b0, irq_o}, 0);
        tick(1); rd(A_CNT, v); chk("R4 zero", v, 0);
        chk("R5 ien off", {31'b0, irq_o}, 0);
        wr(A_CTRL, 3); chk("R5 late enable", {31'b0, irq_o}, 1);
        tick(3); rd(A_CNT, v); chk("R4 held", v, 0);
    endtask

    task automatic t_clear();
        wr(A_CTRL, 0); chk("R10 off", {31'b0, irq_o}, 0);
        wr(A_CTRL, 32'h12); chk("R7 closed gate", {31'b0, irq_o}, 1);
        wr(A_CTRL, 32'h13); chk("R7 first write", {31'b0, irq_o}, 1);
        wr(A_CTRL, 32'h13); chk("R7 second write", {31'b0, irq_o}, 0);
    endtask

    task automatic t_gate();
        logic [31:0] v;
        wr(A_CTRL, 2);
        wr(A_CNT, 9); rd(A_CNT, v); chk("R6 ignored", v, 0);
        tick(3); rd(A_CNT, v); chk("R6 no start", v, 0);
        wr(A_CTRL, 3); tick(2);
        rd(A_CNT, v); chk("R9 no restart", v, 0);
        chk("R6 no irq", {31'b0, irq_o}, 0);
    endtask

    task automatic t_freeze();
        logic [31:0] v;
        wr(A_CNT, 10); tick(3);
        rd(A_CNT, v); chk("R3 count", v, 7);
        wr(A_CTRL, 2); rd(A_CNT, v); chk("R8 last tick", v, 6);
        tick(4); rd(A_CNT, v); chk("R8 frozen", v, 6);
        wr(A_CTRL, 3); rd(A_CNT, v); chk("R8 reopen", v, 6);
        tick(2); rd(A_CNT, v); chk("R8 resumed", v, 4);
        tick(3); chk("R4 before end", {31'b0, irq_o}, 0);
        tick(1); chk("R4 expiry", {31'b0, irq_o}, 1);
        wr(A_CTRL, 0); tick(2);
        chk("R10 irq low", {31'b0, irq_o}, 0);
        wr(A_CTRL, 3); clear_pend();
    endtask

    task automatic t_zero();
        wr(A_CNT, 0); chk("R4 zero pending later", {31'b0, irq_o}, 0);
        tick(1); chk("R4 zero expiry", {31'b0, irq_o}, 1);
        clear_pend();
    endtask

    task automatic t_restart();
        logic [31:0] v;
        wr(A_CNT, 8); tick(2);
        rd(A_CNT, v); chk("R13 before", v, 6);
        wr(A_CNT, 3); rd(A_CNT, v); chk("R13 reload", v, 3);
        tick(2); chk("R13 early", {31'b0, irq_o}, 0);
        tick(1); chk("R13 expiry", {31'b0, irq_o}, 1);
        clear_pend();
    endtask

    task automatic t_max();
        logic [31:0] v;
        wr(A_CNT, 32'hFFFF_FFFF); rd(A_CNT, v); chk("R12 load", v, 32'hFFFF_FFFF);
        tick(1); rd(A_CNT, v); chk("R12 dec", v, 32'hFFFF_FFFE);
    endtask

    task automatic t_collide();
        wr(A_CNT, 1); tick(1);
        chk("R11 setup", {31'b0, irq_o}, 1);
        wr(A_CNT, 2); chk("R11 reload keeps", {31'b0, irq_o}, 1);
        tick(1);
        wr(A_CTRL, 32'h13); chk("R11 set wins", {31'b0, irq_o}, 1);
        clear_pend();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_countdown();
        t_clear();
        t_gate();
        t_freeze();
        t_zero();
        t_restart();
        t_max();
        t_collide();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule